// File: doc/BRIEF.md
# Coin accumulating vending controller

This block controls a single-slot coin acceptor. It takes nickels (5 cents) and dimes (10 cents) and releases one item once the deposited total reaches 15 cents. The credit is held as a count of nickels in a two-bit register, so it always takes one of four values: 0, 5, 10 or 15 cents. Any overpayment is absorbed into the 15-cent state, and no change is given.

Each coin sensor delivers a pulse one clock cycle long. The release output depends only on registered state, as in a Moore machine. It stays high for exactly one cycle per sale. In the cycle after a sale the credit clears, ready for the next customer. Any coin sensed during the release cycle is discarded. The reset input is asynchronous and active-low. It is expected to arrive already synchronised to `clk`.

Top module: `vend_credit_ctrl`

## Requirements
- R1: Reset (rst_n low) forces release_o low and the credit to 0 cents, including in the middle of a purchase. After reset, exactly three nickels are needed for a sale.
- R2: A nickel adds 5 cents. Three nickels raise release_o in the cycle that follows the clock edge sampling the third nickel.
- R3: A dime adds 10 cents. Nickel then dime, or dime then nickel, raises release_o after the second coin.
- R4: From 10 cents, either coin moves the credit to 15 cents and triggers a sale. The surplus 5 cents is dropped and is not carried into the next sale.
- R5: A cycle with no coin leaves the credit unchanged, however many such cycles pass.
- R6: A cycle with both coin inputs high is treated as no coin: the credit is unchanged.
- R7: release_o is high only while the credit is 15 cents (encoding 2'b11; 0, 5 and 10 cents are 2'b00, 2'b01 and 2'b10). It is high for one cycle per sale. With a nickel held high continuously, it pulses once every four cycles.
- R8: After the release cycle the credit returns to 0 cents. Coins sampled at that edge are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| coin_nickel | input | 1 | One-cycle pulse: a 5-cent coin was sensed |
| coin_dime | input | 1 | One-cycle pulse: a 10-cent coin was sensed |
| release_o | output | 1 | Registered item-release strobe, one cycle per sale |

## Verification
The bench targets the following corner cases, each of which a faulty design would show at release_o:
- **Dime at 10 cents.** A design without saturation would wrap the credit and never release.
- **Coin during the release cycle.** A design that accepts this coin would start the next sale with credit and release early.
- **Both inputs high.** A design that counts this as a nickel or a dime would release one coin too soon.
- **Nickel held high continuously.** A design that holds release_o high, or that does not clear the credit, would show a pulse spacing other than four cycles.
- **Reset in the middle of a purchase.** A design that keeps stale credit would release after fewer than three nickels.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // Credit is a count of nickels; full scale is the sale threshold.
  localparam int unsigned CREDIT_W = 2;

  typedef logic [CREDIT_W-1:0] credit_t;

  localparam credit_t CREDIT_ZERO = '0;
  localparam credit_t CREDIT_FULL = '1;
  localparam credit_t STEP_NONE   = credit_t'(0);
  localparam credit_t STEP_NICKEL = credit_t'(1);
  localparam credit_t STEP_DIME   = credit_t'(2);
endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
(
  input  logic    coin_nickel,
  input  logic    coin_dime,
  output credit_t step
);
  // Exactly one sensor active selects a step; none or both give no step.
  always_comb begin
    step = STEP_NONE;
    if (coin_nickel && !coin_dime) begin
      step = STEP_NICKEL;
    end else if (coin_dime && !coin_nickel) begin
      step = STEP_DIME;
    end
  end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
  import vend_pkg::*;
(
  input  credit_t credit_q,
  input  credit_t step,
  output credit_t credit_d,
  output logic    credit_en,
  output logic    release_d
);
  localparam int unsigned SUM_W = CREDIT_W + 1;

  logic [SUM_W-1:0] sum;
  logic             at_full;

  assign at_full = (credit_q == CREDIT_FULL);
  assign sum     = {1'b0, credit_q} + {1'b0, step};

  always_comb begin
    if (at_full) begin
      credit_d = CREDIT_ZERO;               // sale done, drop any coin
    end else if (sum >= {1'b0, CREDIT_FULL}) begin
      credit_d = CREDIT_FULL;               // saturate, surplus absorbed
    end else begin
      credit_d = sum[CREDIT_W-1:0];
    end
  end

  // Register only moves on a coin or when leaving the full state.
  assign credit_en = at_full || (step != STEP_NONE);
  assign release_d = !at_full && (credit_d == CREDIT_FULL);
endmodule

// File: rtl/vend_credit_ctrl.sv
module vend_credit_ctrl
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic coin_nickel,
  input  logic coin_dime,
  output logic release_o
);
  credit_t step;
  credit_t credit_q;
  credit_t credit_d;
  logic    credit_en;
  logic    release_d;
  logic    release_q;

  vend_coin_decode u_decode (
    .coin_nickel (coin_nickel),
    .coin_dime   (coin_dime),
    .step        (step)
  );

  vend_credit_next u_next (
    .credit_q  (credit_q),
    .step      (step),
    .credit_d  (credit_d),
    .credit_en (credit_en),
    .release_d (release_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= CREDIT_ZERO;
    end else if (credit_en) begin
      credit_q <= credit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
    end else begin
      release_q <= release_d;
    end
  end

  assign release_o = release_q;
endmodule

// File: rtl/vend_credit_chk.sv
module vend_credit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       coin_nickel,
  input logic       coin_dime,
  input logic       release_o,
  input logic [1:0] credit
);
  // R1: first cycle out of reset sees cleared state
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (credit == 2'b00 && !release_o));

  // R2: nickel below full adds one step
  p_nickel_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (credit != 2'b11 && coin_nickel && !coin_dime) |=> (credit == $past(credit) + 2'd1));

  // R3: dime from zero lands on ten cents
  p_dime_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (credit == 2'b00 && coin_dime && !coin_nickel) |=> (credit == 2'b10));

  // R4: dime from five or ten saturates at fifteen
  p_dime_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((credit == 2'b01 || credit == 2'b10) && coin_dime && !coin_nickel) |=> (credit == 2'b11));

  // R5: idle cycle holds credit below full
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (credit != 2'b11 && !coin_nickel && !coin_dime) |=> $stable(credit));

  // R6: both inputs high holds credit below full
  p_both_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (credit != 2'b11 && coin_nickel && coin_dime) |=> $stable(credit));

  // R7: release tracks the full state and lasts one cycle
  p_release_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    release_o == (credit == 2'b11));
  p_release_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !release_o);

  // R8: full state always clears, whatever coin arrives
  p_full_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (credit == 2'b11) |=> (credit == 2'b00));
endmodule

bind vend_credit_ctrl vend_credit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .coin_nickel (coin_nickel),
  .coin_dime   (coin_dime),
  .release_o   (release_o),
  .credit      (credit_q)
);

// File: tb/tb_vend_credit_ctrl.sv
`timescale 1ns/1ps
module tb_vend_credit_ctrl;
  logic clk;
  logic rst_n;
  logic coin_nickel;
  logic coin_dime;
  logic release_o;

  int checks = 0;
  int errors = 0;

  vend_credit_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .coin_nickel (coin_nickel),
    .coin_dime   (coin_dime),
    .release_o   (release_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic expect_rel(input logic exp, input string tag);
    checks++;
    if (release_o !== exp) begin
      errors++;
      $display("FAIL %s: release_o=%b expected %b", tag, release_o, exp);
    end
  endtask

  // Drive inputs at negedge, sample 1 ns after the capturing posedge.
  task automatic coin(input logic n, input logic d, input logic exp, input string tag);
    @(negedge clk);
    coin_nickel = n;
    coin_dime   = d;
    @(posedge clk);
    #1;
    expect_rel(exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n       = 1'b0;
    coin_nickel = 1'b0;
    coin_dime   = 1'b0;
    repeat (2) @(negedge clk);
    expect_rel(1'b0, "R1 during reset");
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    coin(0, 0, 0, "R1 idle after reset");
    coin(1, 0, 0, "R1 nickel 1");
    coin(1, 0, 0, "R1 nickel 2");
    do_reset();                                  // mid-purchase reset at 10 cents
    coin(1, 0, 0, "R1 post-reset nickel 1");
    coin(1, 0, 0, "R1 post-reset nickel 2");
    coin(1, 0, 1, "R1 post-reset nickel 3");
    coin(0, 0, 0, "R1 clear");
  endtask

  task automatic t_nickels();
    do_reset();
    coin(1, 0, 0, "R2 nickel 1");
    coin(1, 0, 0, "R2 nickel 2");
    coin(1, 0, 1, "R2 nickel 3 sale");
    coin(0, 0, 0, "R2 release ends");
  endtask

  task automatic t_dimes();
    do_reset();
    coin(1, 0, 0, "R3 nickel first");
    coin(0, 1, 1, "R3 then dime sale");
    coin(0, 0, 0, "R3 gap");
    coin(0, 1, 0, "R3 dime first");
    coin(1, 0, 1, "R3 then nickel sale");
    coin(0, 0, 0, "R3 gap 2");
  endtask

  task automatic t_overpay();
    do_reset();
    coin(0, 1, 0, "R4 dime 1");
    coin(0, 1, 1, "R4 dime at 10 saturates");
    coin(0, 0, 0, "R4 gap");
    coin(1, 0, 0, "R4 no carry nickel 1");
    coin(1, 0, 0, "R4 no carry nickel 2");
    coin(1, 0, 1, "R4 no carry nickel 3");
    coin(0, 0, 0, "R4 gap 2");
    coin(1, 0, 0, "R4 nickel");
    coin(1, 0, 0, "R4 nickel to 10");
    coin(0, 1, 1, "R4 dime at 10 sale");
    coin(0, 0, 0, "R4 gap 3");
  endtask

  task automatic t_idle_hold();
    do_reset();
    coin(1, 0, 0, "R5 nickel 1");
    for (int i = 0; i < 4; i++) coin(0, 0, 0, "R5 hold at 5");
    coin(1, 0, 0, "R5 nickel 2");
    for (int i = 0; i < 3; i++) coin(0, 0, 0, "R5 hold at 10");
    coin(1, 0, 1, "R5 nickel 3 sale");
    coin(0, 0, 0, "R5 end");
  endtask

  task automatic t_both();
    do_reset();
    coin(1, 1, 0, "R6 both at 0");
    coin(1, 1, 0, "R6 both at 0 again");
    coin(0, 1, 0, "R6 dime after both");
    coin(1, 1, 0, "R6 both at 10");
    coin(1, 0, 1, "R6 nickel sale");
    coin(0, 0, 0, "R6 gap");
    coin(1, 0, 0, "R6 nickel to 5");
    coin(1, 1, 0, "R6 both at 5");
    coin(1, 0, 0, "R6 nickel to 10");
    coin(1, 0, 1, "R6 nickel sale 2");
    coin(0, 0, 0, "R6 end");
  endtask

  task automatic t_pulse();
    do_reset();
    // Continuous nickel: 5,10,15(sale),0(ignored),5,10,15(sale),0
    coin(1, 0, 0, "R7 held cycle 1");
    coin(1, 0, 0, "R7 held cycle 2");
    coin(1, 0, 1, "R7 held cycle 3 sale");
    coin(1, 0, 0, "R7 held cycle 4 one-cycle pulse");
    coin(1, 0, 0, "R7 held cycle 5");
    coin(1, 0, 0, "R7 held cycle 6");
    coin(1, 0, 1, "R7 held cycle 7 sale");
    coin(0, 0, 0, "R7 end");
  endtask

  task automatic t_release_ignore();
    do_reset();
    coin(0, 1, 0, "R8 dime");
    coin(1, 0, 1, "R8 sale");
    coin(0, 1, 0, "R8 dime in release cycle ignored");
    coin(0, 1, 0, "R8 dime to 10 only");
    coin(1, 0, 1, "R8 nickel sale");
    coin(0, 0, 0, "R8 end");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    coin_nickel = 1'b0;
    coin_dime   = 1'b0;
    repeat (2) @(negedge clk);
    expect_rel(1'b0, "R1 initial reset");
    rst_n = 1'b1;
    t_reset();
    t_nickels();
    t_dimes();
    t_overpay();
    t_idle_hold();
    t_both();
    t_pulse();
    t_release_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule